// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block is the controller-side bring-up engine for a two-bank SDRAM. When reset is released it keeps clock enable high and every data-mask line high, and it drives NOP on the command pins until a stabilization interval has passed. The interval is given in microseconds and converted to clock cycles from the configured clock frequency. The block then precharges both banks at once and waits the precharge time. It issues a configurable number of auto-refresh commands, each one refresh-cycle time after the one before. Last of all it loads the mode register, and after the mode-register recovery time it raises a sticky ready flag.

The mode word comes from three inputs: a burst length code, a burst type bit and a CAS latency. The word is packed onto the address bus in the MRS cycle. The wait times are parameters in clock cycles. Between commands the pins carry NOP, and the bank address stays zero. Once ready is high the block drives only NOP and releases the data masks, so the normal traffic controller can take over.

Top module: `sdram_init_seq`

## Requirements
- R1: While ready_o is low, every dqm_o bit is high. Counting cycles from the first rising edge after reset release as cycle 0, the command pins carry NOP for the first CLK_MHZ*STABLE_US cycles, and the first command (precharge) appears in the cycle that follows.
- R2: The precharge command is {cs_n,ras_n,cas_n,we_n}=0010 with address bit 10 high and all other address bits low (precharge all banks).
- R3: The first auto-refresh ({cs_n,ras_n,cas_n,we_n}=0001) appears exactly T_RP cycles after the precharge.
- R4: Exactly NUM_REF auto-refresh commands are issued, each exactly T_RC cycles after the one before it.
- R5: The mode register set ({cs_n,ras_n,cas_n,we_n}=0000) appears exactly T_RC cycles after the last refresh. In that cycle address bits 7 and up are zero and ba_o is zero.
- R6: In the MRS cycle, address bits 2:0 equal the burst length code mode_bl_i (0,1,2,3 for lengths 1,2,4,8), bit 3 equals mode_bt_i (0 sequential, 1 interleave), and bits 6:4 equal the CAS latency mode_cl_i (1 to 3) zero-extended to three bits.
- R7: ready_o rises exactly T_MRD cycles after the MRS and stays high until reset. While it is high, the pins carry only NOP.
- R8: In every cycle with no scheduled command, the pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111) with the address bus at zero.
- R9: cke_o is high in every cycle. Once ready_o is high, every dqm_o bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_bl_i | input | 2 | Burst length code: 0,1,2,3 select 1,2,4,8 |
| mode_bt_i | input | 1 | Burst type: 0 sequential, 1 interleave |
| mode_cl_i | input | 2 | CAS latency 1 to 3 |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| dqm_o | output | DQM_W | Data-mask lines |
| ready_o | output | 1 | Initialization complete, sticky |

## Verification
Two things can land in the same cycle. The refresh count can reach its limit in the cycle the last refresh fires, which must send the sequence straight to MRS with no extra refresh. The recovery timer can run out in the cycle ready must rise. A second instance with every spacing set to one cycle and a three-cycle stabilization puts these back to back, and it is run again under several mode codes. A behavioural schedule model in the bench predicts the pins for every cycle, and each cycle of both instances is compared against it. A reset applied in the middle of a run checks that the sequence starts over.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_REF,
    PH_MRS,
    PH_MRD,
    PH_READY
  } init_phase_e;
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TMR_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= TMR_W'(RST_VAL);
    else if (load_i)  cnt_q <= load_val_i;
    else if (!zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o); // R3
  AST_TMR_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/sdram_ref_counter.sv
module sdram_ref_counter #(
  parameter int NUM_REF = 8,
  localparam int CNT_W  = $clog2(NUM_REF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(NUM_REF - 1));

  AST_REF_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_REF)); // R4
  AST_REF_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(NUM_REF)) |-> !inc_i); // R4
endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bl_i,
  input  logic              bt_i,
  input  logic [1:0]        cl_i,
  output logic [ADDR_W-1:0] word_o
);
  always_comb begin
    word_o      = '0;
    word_o[2:0] = {1'b0, bl_i};
    word_o[3]   = bt_i;
    word_o[6:4] = {1'b0, cl_i};
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int STABLE_US = 500,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int NUM_REF   = 8,
  parameter int ADDR_W    = 11,
  parameter int BANK_W    = 1,
  parameter int DQM_W     = 8,
  parameter int AP_BIT    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_bl_i,
  input  logic              mode_bt_i,
  input  logic [1:0]        mode_cl_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              ready_o
);
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int MAX_A = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int MAX_B = (MAX_A > T_MRD) ? MAX_A : T_MRD;
  localparam int MAX_W = (STABLE_CYC > MAX_B) ? STABLE_CYC : MAX_B;
  localparam int TMR_W = $clog2(MAX_W + 1);

  init_phase_e      phase_q, phase_d;
  sdram_cmd_e       cmd;
  logic             tmr_load, tmr_zero, ref_inc, ref_last;
  logic [TMR_W-1:0] tmr_val;
  logic [ADDR_W-1:0] mode_word;

  sdram_init_timer #(.TMR_W(TMR_W), .RST_VAL(STABLE_CYC)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  sdram_ref_counter #(.NUM_REF(NUM_REF)) u_refcnt (
    .clk_i, .rst_ni, .inc_i(ref_inc), .last_o(ref_last)
  );

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .bl_i(mode_bl_i), .bt_i(mode_bt_i), .cl_i(mode_cl_i), .word_o(mode_word)
  );

  always_comb begin
    phase_d  = phase_q;
    cmd      = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_inc  = 1'b0;
    unique case (phase_q)
      PH_WAIT: if (tmr_zero) begin
        cmd = CMD_PRE; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1); phase_d = PH_REF;
      end
      PH_REF: if (tmr_zero) begin
        cmd = CMD_REF; ref_inc = 1'b1; tmr_load = 1'b1; tmr_val = TMR_W'(T_RC - 1);
        if (ref_last) phase_d = PH_MRS;
      end
      PH_MRS: if (tmr_zero) begin
        cmd = CMD_MRS; tmr_load = 1'b1; tmr_val = TMR_W'(T_MRD - 1); phase_d = PH_MRD;
      end
      PH_MRD: if (tmr_zero) phase_d = PH_READY;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_WAIT;
    else         phase_q <= phase_d;
  end

  always_comb begin
    addr_o = '0;
    if (cmd == CMD_PRE)      addr_o[AP_BIT] = 1'b1;
    else if (cmd == CMD_MRS) addr_o = mode_word;
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign ba_o    = '0;
  assign cke_o   = 1'b1;
  assign ready_o = (phase_q == PH_READY) || (phase_q == PH_MRD && tmr_zero);
  assign dqm_o   = {DQM_W{~ready_o}};

  AST_MASK_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (dqm_o == {DQM_W{1'b1}})); // R1
  AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> addr_o[AP_BIT]); // R2
  AST_MRS_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MRS) |-> (addr_o[ADDR_W-1:7] == '0)); // R5
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R7
  AST_QUIET_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cmd == CMD_NOP)); // R7
  AST_REF_AFTER_REF_OR_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_REF) |-> (phase_q == PH_REF)); // R4
endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int M_S = 50000, M_RP = 3, M_RC = 7, M_MRD = 2, M_N = 8;
  localparam int F_S = 3, F_RP = 1, F_RC = 1, F_MRD = 1, F_N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bl = 2'd3, cl = 2'd3;
  logic bt = 1'b1;
  int n_chk = 0, n_bad = 0, cyc_m = 0, cyc_f = 0, total = 0;

  always #5 clk = ~clk;

  logic cke_m, cs_m, ras_m, cas_m, we_m, rdy_m;
  logic [0:0] ba_m; logic [10:0] ad_m; logic [7:0] dq_m;
  logic cke_f, cs_f, ras_f, cas_f, we_f, rdy_f;
  logic [0:0] ba_f; logic [10:0] ad_f; logic [7:0] dq_f;

  sdram_init_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_bl_i(bl), .mode_bt_i(bt), .mode_cl_i(cl),
    .cke_o(cke_m), .cs_n_o(cs_m), .ras_n_o(ras_m), .cas_n_o(cas_m), .we_n_o(we_m),
    .ba_o(ba_m), .addr_o(ad_m), .dqm_o(dq_m), .ready_o(rdy_m));

  sdram_init_seq #(.CLK_MHZ(1), .STABLE_US(F_S), .T_RP(F_RP), .T_RC(F_RC),
                   .T_MRD(F_MRD), .NUM_REF(F_N)) dut_min (
    .clk_i(clk), .rst_ni(rst_n), .mode_bl_i(bl), .mode_bt_i(bt), .mode_cl_i(cl),
    .cke_o(cke_f), .cs_n_o(cs_f), .ras_n_o(ras_f), .cas_n_o(cas_f), .we_n_o(we_f),
    .ba_o(ba_f), .addr_o(ad_f), .dqm_o(dq_f), .ready_o(rdy_f));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin cyc_m <= 0; cyc_f <= 0; end
    else begin cyc_m <= cyc_m + 1; cyc_f <= cyc_f + 1; end

  always @(posedge clk) total <= total + 1;

  // schedule model: 0 NOP, 1 PRE, 2 first REF, 3 later REF, 4 MRS
  function automatic int sched(int c, int s, int trp, int trc, int n);
    if (c == s) return 1;
    for (int k = 0; k < n; k++)
      if (c == s + trp + k * trc) return (k == 0) ? 2 : 3;
    if (c == s + trp + n * trc) return 4;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare(string who, int c, int s, int trp, int trc, int n, int tmrd,
                         logic [3:0] cmd, logic [10:0] ad, logic [7:0] dq,
                         logic ck, logic rd, logic [0:0] ba);
    int ev = sched(c, s, trp, trc, n);
    int er = (c >= s + trp + n * trc + tmrd) ? 1 : 0;
    logic [3:0] ec;
    logic [10:0] ea;
    string tc, ta;
    ec = 4'b0111; ea = '0; tc = "R8"; ta = "R8";
    case (ev)
      1: begin ec = 4'b0010; ea = 11'h400; tc = "R1"; ta = "R2"; end
      2: begin ec = 4'b0001; tc = "R3"; end
      3: begin ec = 4'b0001; tc = "R4"; end
      4: begin ec = 4'b0000; ea = {4'b0, 1'b0, cl, bt, 1'b0, bl}; tc = "R5"; ta = "R6"; end
      default: ;
    endcase
    if (er == 1) tc = "R7";
    chk(tc, {who, " cmd"}, cmd, ec);
    chk(ta, {who, " addr"}, ad, ea);
    chk("R7", {who, " ready"}, rd, er);
    chk(er ? "R9" : "R1", {who, " dqm"}, dq, er ? 8'h00 : 8'hff);
    chk("R9", {who, " cke"}, ck, 1);
    if (ev == 4) chk("R5", {who, " ba"}, ba, 0);
  endtask

  bit run_cmp = 1'b1;
  always @(negedge clk) if (run_cmp) begin
    compare("main", cyc_m, M_S, M_RP, M_RC, M_N, M_MRD,
            {cs_m, ras_m, cas_m, we_m}, ad_m, dq_m, cke_m, rdy_m, ba_m);
    compare("min", cyc_f, F_S, F_RP, F_RC, F_N, F_MRD,
            {cs_f, ras_f, cas_f, we_f}, ad_f, dq_f, cke_f, rdy_f, ba_f);
  end

  task automatic drive_cycles(int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  initial begin
    @(posedge clk); #2;
    drive_cycles(3);
    rst_n = 1'b1;
    // full run of both instances; mode change well before MRS of main
    drive_cycles(30000);
    bl = 2'd2; bt = 1'b0; cl = 2'd2;
    drive_cycles(20200);
    // R7 ready held, then restart mid-run and repeat fast sequence with other codes
    for (int p = 0; p < 4; p++) begin
      rst_n = 1'b0;
      bl = 2'(p); bt = p[0]; cl = 2'(1 + (p % 3));
      drive_cycles(2);
      rst_n = 1'b1;
      drive_cycles(25 + p);
    end
    run_cmp = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (total >= 150000);
    run_cmp = 1'b0;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", total);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule